// File: doc/BRIEF.md
# Transmit Queue Stop-and-Drain Sequencer

This block shuts down one hardware transmit queue and makes sure the queue is empty. A one-cycle stop request carries a queue index. If that queue is marked active, the sequencer runs a fixed sequence:

1. It arms the queue's early-termination control, so that frames still queued are flushed quickly.
2. It raises the queue's disable strobe.
3. It waits for the queue's enabled status to drop.
4. It watches the count of frames still pending on that queue until the count is zero or the poll budget is used up.

If frames are still pending after this first drain and escalation is allowed for the request, the sequencer enters a quiet phase:

- It programs a quiet period with periodicity 100 and duration 10. The next quiet start is the low 32 bits of the timestamp shifted right by 10.
- It turns the quiet mechanism on and forces the channel-idle indication high for a fixed wait, then turns the quiet mechanism off.
- It polls the pending count again with a smaller budget, then releases the forced idle.

All waits are counted in pulses of a one-cycle microsecond tick input, so the surrounding logic or a testbench can compress time. The sequence always ends by clearing early termination and the disable strobe. It then reports, with a one-cycle done pulse, whether the queue drained.

Top module: `txq_stop_seq`

## Requirements
- R1: A stop request whose queue bit in `q_active_i` is 0 is rejected. In the next cycle `done_o` pulses with `status_o` = 2 (invalid). `busy_o` stays low. Early termination, the disable strobe, quiet enable and forced idle are never asserted.
- R2: For an accepted request, `early_term_o` is high before the disable strobe is raised, and stays high while it is raised. The disable strobe `txd_o` is one-hot, with only the bit at the requested queue index set.
- R3: The enabled-status poll runs at most EN_POLLS times, POLL_US ticks apart. The sequence moves on as soon as the queue reads disabled, or when the polls are used up, even if the queue stays enabled.
- R4: The pending count is sampled at most PEND_POLLS1 times, each sample followed by a POLL_US tick wait. The poll stops after the first sample that reads zero.
- R5: The quiet phase is entered only if the last sample was nonzero and escalation was requested. When it is entered, `quiet_per_o` = 100, `quiet_dur_o` = 10 and `quiet_next_o` = `tsf_i` >> 10.
- R6: While `quiet_en_o` is high, `idle_force_o` is high. Quiet enable lasts QUIET_US ticks. Forced idle stays high through the re-poll of at most PEND_POLLS2 samples and is low at the done pulse.
- R7: In the done cycle, `early_term_o` is 0 and `txd_o` is 0. `status_o` is 0 (ok) if the last pending sample was zero and 1 (busy) if it was not.
- R8: A stop request that arrives while a sequence runs is ignored. The queue being stopped does not change, and there is no extra done pulse.
- R9: `busy_o` is high from the cycle after an accepted request until it falls in the cycle that `done_o` pulses. `done_o` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_req_i | input | 1 | One-cycle stop request |
| stop_q_i | input | QW | Queue index of the request |
| escalate_en_i | input | 1 | Allow the quiet-phase escalation for this request |
| q_active_i | input | NUM_Q | Per-queue active flags |
| us_tick_i | input | 1 | One-cycle microsecond tick |
| q_txe_i | input | NUM_Q | Per-queue enabled status |
| pend_cnt_i | input | PEND_W | Pending frame count of the queue on `sel_q_o` |
| tsf_i | input | TSF_W | Low timestamp word |
| sel_q_o | output | QW | Queue being stopped |
| early_term_o | output | 1 | Early-termination enable |
| txd_o | output | NUM_Q | Disable strobe, one bit per queue |
| quiet_en_o | output | 1 | Quiet mechanism enable |
| quiet_per_o | output | 8 | Quiet periodicity |
| quiet_dur_o | output | 8 | Quiet duration |
| quiet_next_o | output | TSF_W-10 | Next quiet start |
| idle_force_o | output | 1 | Forced channel-idle override |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 busy (frames left), 2 invalid queue |

## Verification
The main sequence is driven from a table of queue behaviours:

- **Prompt stop, nothing pending:** shows the fast path.
- **Pending frames that drain under early termination:** separates the first drain from escalation.
- **Leftover frames with escalation off:** shows busy is reported without any quiet activity.
- **Frames that drain only while idle is forced:** an ok result after the quiet phase.
- **A backlog too large to clear:** a busy result after the quiet phase.
- **A queue whose enabled status never drops:** shows that the enabled-status poll gives up after its budget.

Directed cases cover the reset state, a stop of an inactive queue, and a second request issued in the middle of a sequence.

// File: rtl/txq_stop_pkg.sv
package txq_stop_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_EARLY, S_DIS, S_EN_CHK, S_EN_WAIT, S_PD_CHK, S_PD_WAIT,
    S_QUIET, S_QWAIT, S_RP_CHK, S_RP_WAIT, S_FIN
  } seq_state_e;

  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_BUSY    = 2'd1;
  localparam logic [1:0] ST_INVALID = 2'd2;

  localparam int QUIET_SHIFT = 10;
  localparam logic [7:0] QUIET_PER = 8'd100;
  localparam logic [7:0] QUIET_DUR = 8'd10;
endpackage

// File: rtl/txq_tick_wait.sv
module txq_tick_wait #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic [CW-1:0] lim_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/txq_poll_cnt.sv
module txq_poll_cnt #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/txq_stop_seq.sv
module txq_stop_seq
  import txq_stop_pkg::*;
#(
  parameter int NUM_Q       = 8,
  parameter int PEND_W      = 10,
  parameter int TSF_W       = 32,
  parameter int POLL_US     = 100,
  parameter int QUIET_US    = 400,
  parameter int EN_POLLS    = 1000,
  parameter int PEND_POLLS1 = 1000,
  parameter int PEND_POLLS2 = 100,
  localparam int QW  = $clog2(NUM_Q),
  localparam int NW  = TSF_W - QUIET_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_req_i,
  input  logic [QW-1:0]     stop_q_i,
  input  logic              escalate_en_i,
  input  logic [NUM_Q-1:0]  q_active_i,
  input  logic              us_tick_i,
  input  logic [NUM_Q-1:0]  q_txe_i,
  input  logic [PEND_W-1:0] pend_cnt_i,
  input  logic [TSF_W-1:0]  tsf_i,
  output logic [QW-1:0]     sel_q_o,
  output logic              early_term_o,
  output logic [NUM_Q-1:0]  txd_o,
  output logic              quiet_en_o,
  output logic [7:0]        quiet_per_o,
  output logic [7:0]        quiet_dur_o,
  output logic [NW-1:0]     quiet_next_o,
  output logic              idle_force_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  localparam int TMAX = (QUIET_US > POLL_US) ? QUIET_US : POLL_US;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PMX1 = (EN_POLLS > PEND_POLLS1) ? EN_POLLS : PEND_POLLS1;
  localparam int PMAX = (PMX1 > PEND_POLLS2) ? PMX1 : PEND_POLLS2;
  localparam int PW   = $clog2(PMAX + 1);

  seq_state_e    state_q;
  logic          esc_q, pend_nz_q;
  logic          t_start, t_done, pc_clr, pc_inc;
  logic [TW-1:0] t_lim;
  logic [PW-1:0] pc;
  logic          en_exit, pd_exit, rp_exit;

  assign en_exit = !q_txe_i[sel_q_o] || (pc == PW'(EN_POLLS));
  assign pd_exit = !pend_nz_q || (pc == PW'(PEND_POLLS1));
  assign rp_exit = !pend_nz_q || (pc == PW'(PEND_POLLS2));
  assign t_lim   = (state_q == S_QWAIT) ? TW'(QUIET_US) : TW'(POLL_US);

  always_comb begin
    t_start = 1'b0;
    pc_inc  = 1'b0;
    pc_clr  = 1'b0;
    unique case (state_q)
      S_DIS:     pc_clr = 1'b1;
      S_EN_CHK:  if (en_exit) pc_clr = 1'b1; else begin pc_inc = 1'b1; t_start = 1'b1; end
      S_PD_CHK,
      S_RP_CHK:  begin pc_inc = 1'b1; t_start = 1'b1; end
      S_PD_WAIT: pc_clr = t_done && pd_exit;
      S_QUIET:   begin t_start = 1'b1; pc_clr = 1'b1; end
      default:   ;
    endcase
  end

  txq_tick_wait #(.CW(TW)) u_wait (
    .clk_i, .rst_ni, .start_i(t_start), .tick_i(us_tick_i), .lim_i(t_lim), .done_o(t_done)
  );

  txq_poll_cnt #(.W(PW)) u_polls (
    .clk_i, .rst_ni, .clr_i(pc_clr), .inc_i(pc_inc), .cnt_o(pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      sel_q_o      <= '0;
      esc_q        <= 1'b0;
      pend_nz_q    <= 1'b0;
      early_term_o <= 1'b0;
      txd_o        <= '0;
      quiet_en_o   <= 1'b0;
      quiet_per_o  <= '0;
      quiet_dur_o  <= '0;
      quiet_next_o <= '0;
      idle_force_o <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      status_o     <= ST_OK;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (stop_req_i) begin
          if (!q_active_i[stop_q_i]) begin
            done_o   <= 1'b1;
            status_o <= ST_INVALID;
          end else begin
            sel_q_o   <= stop_q_i;
            esc_q     <= escalate_en_i;
            pend_nz_q <= 1'b0;
            busy_o    <= 1'b1;
            state_q   <= S_EARLY;
          end
        end
        S_EARLY: begin early_term_o <= 1'b1; state_q <= S_DIS; end
        S_DIS: begin
          txd_o   <= NUM_Q'(1) << sel_q_o;
          state_q <= S_EN_CHK;
        end
        S_EN_CHK:  state_q <= en_exit ? S_PD_CHK : S_EN_WAIT;
        S_EN_WAIT: if (t_done) state_q <= S_EN_CHK;
        S_PD_CHK: begin pend_nz_q <= |pend_cnt_i; state_q <= S_PD_WAIT; end
        S_PD_WAIT: if (t_done) begin
          if (!pd_exit)      state_q <= S_PD_CHK;
          else if (pend_nz_q && esc_q) state_q <= S_QUIET;
          else               state_q <= S_FIN;
        end
        S_QUIET: begin
          quiet_per_o  <= QUIET_PER;
          quiet_dur_o  <= QUIET_DUR;
          quiet_next_o <= NW'(tsf_i >> QUIET_SHIFT);
          quiet_en_o   <= 1'b1;
          idle_force_o <= 1'b1;
          state_q      <= S_QWAIT;
        end
        S_QWAIT: if (t_done) begin quiet_en_o <= 1'b0; state_q <= S_RP_CHK; end
        S_RP_CHK: begin pend_nz_q <= |pend_cnt_i; state_q <= S_RP_WAIT; end
        S_RP_WAIT: if (t_done) begin
          if (rp_exit) begin idle_force_o <= 1'b0; state_q <= S_FIN; end
          else state_q <= S_RP_CHK;
        end
        S_FIN: begin
          early_term_o <= 1'b0;
          txd_o        <= '0;
          busy_o       <= 1'b0;
          done_o       <= 1'b1;
          status_o     <= pend_nz_q ? ST_BUSY : ST_OK;
          state_q      <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R9
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy_o) |-> done_o);
  // R2
  early_before_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (|txd_o) |-> early_term_o);
  // R2
  txd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(txd_o));
  // R6
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) quiet_en_o |-> idle_force_o);
  // R7
  fin_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!early_term_o && txd_o == '0 && !idle_force_o && !quiet_en_o));
  // R1
  invalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == ST_INVALID) |-> (!busy_o && !early_term_o));
  // R8
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(sel_q_o));
  // R5
  quiet_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(quiet_en_o) |-> (quiet_per_o == QUIET_PER && quiet_dur_o == QUIET_DUR));
endmodule

// File: tb/sim_txq_stop_seq.sv
module sim_txq_stop_seq;
  localparam int CLK_P = 10;
  localparam int NQ = 8, PW = 10, TW = 32;
  localparam int POLL = 4, QUI = 10, ENP = 6, PP1 = 6, PP2 = 3;

  typedef struct packed {
    logic [2:0] q;
    logic       esc;
    logic [7:0] lag;    // 255: enabled status never drops
    logic [9:0] pend0;
    logic       dn;     // drains under early termination
    logic       di;     // drains under forced idle
    logic [1:0] exp_st;
    logic       exp_qt;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd2, 1'b1, 8'd3,   10'd0,   1'b0, 1'b0, 2'd0, 1'b0},
    '{3'd5, 1'b1, 8'd2,   10'd8,   1'b1, 1'b0, 2'd0, 1'b0},
    '{3'd1, 1'b0, 8'd1,   10'd3,   1'b0, 1'b0, 2'd1, 1'b0},
    '{3'd7, 1'b1, 8'd1,   10'd15,  1'b0, 1'b1, 2'd0, 1'b1},
    '{3'd3, 1'b1, 8'd1,   10'd500, 1'b0, 1'b1, 2'd1, 1'b1},
    '{3'd0, 1'b1, 8'd255, 10'd0,   1'b0, 1'b0, 2'd0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic stop_req = 0, esc = 0, tick = 1;
  logic [2:0] stop_q = '0;
  logic [NQ-1:0] active = 8'hBF, txe = '1;
  logic [PW-1:0] pend = '0;
  logic [TW-1:0] tsf = 32'h0ABC_D400;
  logic [2:0] sel_q;
  logic early, quiet_en, idle, busy, done;
  logic [NQ-1:0] txd;
  logic [7:0] qper, qdur;
  logic [21:0] qnext;
  logic [1:0] status;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  txq_stop_seq #(.NUM_Q(NQ), .PEND_W(PW), .TSF_W(TW), .POLL_US(POLL), .QUIET_US(QUI),
    .EN_POLLS(ENP), .PEND_POLLS1(PP1), .PEND_POLLS2(PP2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .stop_q_i(stop_q),
    .escalate_en_i(esc), .q_active_i(active), .us_tick_i(tick), .q_txe_i(txe),
    .pend_cnt_i(pend), .tsf_i(tsf), .sel_q_o(sel_q), .early_term_o(early), .txd_o(txd),
    .quiet_en_o(quiet_en), .quiet_per_o(qper), .quiet_dur_o(qdur), .quiet_next_o(qnext),
    .idle_force_o(idle), .busy_o(busy), .done_o(done), .status_o(status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_vec(input vec_t v, input bit poke);
    int el = 0, txcnt = 0, qcyc = 0, extra = 0;
    bit seen_tx = 0, seen_q = 0, busy_ok = 1, early_ok = 1, other_q = 0;
    tsf = {8'h1, 5'd0, v.q, 16'hC400};
    txe = '1; pend = v.pend0;
    @(negedge clk);
    stop_req = 1; stop_q = v.q; esc = v.esc;
    @(negedge clk);
    stop_req = 0;
    while (!done && el < 5000) begin
      el++;
      if (poke && el == 5) begin stop_req = 1; stop_q = v.q + 3'd1; end
      else stop_req = 0;
      if (!busy) busy_ok = 0;
      if (|txd) begin
        if (!seen_tx && !early) early_ok = 0;
        if (txd != (8'd1 << v.q)) other_q = 1;
        seen_tx = 1; txcnt++;
        if (v.lag != 8'd255 && txcnt >= v.lag) txe[v.q] = 1'b0;
      end
      if (quiet_en) begin
        if (!seen_q) begin
          chk(qper == 8'd100, "R5 per", qper, 100);
          chk(qdur == 8'd10, "R5 dur", qdur, 10);
          chk(qnext == 22'(tsf >> 10), "R5 next", qnext, 22'(tsf >> 10));
        end
        seen_q = 1; qcyc++;
        chk(idle, "R6 idle with quiet", idle, 1);
      end
      if (early && v.dn && pend > 0) pend--;
      if (idle && v.di && pend > 0) pend--;
      @(negedge clk);
    end
    stop_req = 0;
    chk(done, "R9 done seen", done, 1);
    chk(status == v.exp_st, "R7 status", status, v.exp_st);
    chk(seen_q == v.exp_qt, "R5 quiet entered", seen_q, v.exp_qt);
    chk(!early && txd == 0, "R7 cleared at done", {early, txd}, 0);
    chk(!idle, "R6 idle released", idle, 0);
    chk(!busy && busy_ok, "R9 busy window", busy_ok, 1);
    chk(early_ok && seen_tx, "R2 early before disable", early_ok, 1);
    chk(!other_q, "R2 R8 disable bit", other_q, 0);
    if (v.exp_qt) chk(qcyc >= QUI && qcyc <= QUI + 3, "R6 quiet length", qcyc, QUI);
    if (v.lag == 8'd255) chk(el >= ENP * POLL, "R3 poll budget", el, ENP * POLL);
    if (v.pend0 == 0 && v.lag != 8'd255) chk(el < PP1 * POLL, "R4 early exit", el, PP1 * POLL);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R8 no extra done", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !early && txd == 0 && !quiet_en && !idle, "reset state", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && txd == 0, "reset release", busy, 0);
    for (int k = 0; k < 6; k++) run_vec(VECS[k], k == 1);
    // R1 inactive queue
    begin
      bit act = 0;
      stop_req = 1; stop_q = 3'd6; esc = 1;
      @(negedge clk);
      stop_req = 0;
      chk(done && status == 2'd2, "R1 invalid status", status, 2);
      for (int i = 0; i < 6; i++) begin
        if (busy || early || |txd || quiet_en || idle) act = 1;
        @(negedge clk);
      end
      chk(!act, "R1 no activity", act, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule